// File: doc/BRIEF.md
# Folded Three-Operand Pipelined Adder

This block sums three signed operands per sample, y = a + b + c, using a single adder that has one internal register stage. The two additions needed per sample share that adder in time: a free-running two-state phase counter steers the adder inputs through multiplexers. In the even phase the two fresh operands a and b go in. In the odd phase the registered partial sum comes back around and meets the third operand c, which was captured in the even phase. The cost is throughput: one sample set is accepted every two clock cycles. The gain is that one adder and one result register do the work of two cascaded adders.

A sample set is offered together with `smp_vld` in an even-phase cycle. The first cycle after the synchronous reset is released is an even phase. The complete sum leaves the adder register two cycles later, qualified by a one-cycle `sum_vld` pulse. In that same cycle the adder is already working on the next pair. Operand values and the strobe are ignored in odd-phase cycles.

Top module: `tri_operand_folded_adder`

## Requirements
- R1: While `rst` is high, and during the first two cycles after it is released, `sum_vld` is low; while `rst` is high `sum_out` reads 0.
- R2: For a sample set accepted in cycle 2k, `sum_out` in cycle 2k+2 equals the exact 18-bit two's-complement sum of the three sign-extended 16-bit operands, with `sum_vld` high.
- R3: `sum_vld` is high for at most one cycle per two-cycle iteration. It is never high in an odd-phase cycle, and never high in two consecutive cycles.
- R4: Operand and strobe values presented in an odd-phase cycle (cycle 2k+1) have no effect on any result.
- R5: When `smp_vld` is low in an even-phase cycle, `sum_vld` stays low two cycles later.
- R6: Extreme operands produce no lost bits: three times -32768 gives -98304 and three times 32767 gives 98301.
- R7: In every odd-phase cycle the adder inputs are the registered partial sum a+b of the current sample and the operand c captured with it.
- R8: Sample sets offered in consecutive even phases, with no gaps, each produce their own correct result, one every two cycles.
- R9: A sample set accepted just before a reset is asserted never produces a `sum_vld` pulse after that reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Sample set present; sampled only in even-phase cycles |
| opd_a | input | 16 | First operand, two's complement |
| opd_b | input | 16 | Second operand, two's complement |
| opd_c | input | 16 | Third operand, two's complement |
| sum_out | output | 18 | Adder register; holds the full sum when `sum_vld` is high |
| sum_vld | output | 1 | One-cycle flag marking a completed three-operand sum |

## Verification
The assertions assume that a sample set is only meaningful when it is presented in an even-phase cycle. They also assume that the sum checked two cycles later comes from the operand values on the ports at that even-phase edge, so the operands need not be held into the odd phase. The stimulus changes inputs only on falling edges. It offers each sample set in the cycle right after reset release or two cycles after the previous one, and deliberately drives conflicting operands with the strobe set in every odd-phase cycle. That keeps both the scheduled sums and the ignored values within what the properties describe.

// File: rtl/fold_add_pkg.sv
package fold_add_pkg;

  // Two-step folding schedule of the shared adder.
  typedef enum logic {
    PH_EVEN = 1'b0,  // fresh operands a and b enter the adder
    PH_ODD  = 1'b1   // partial sum is fed back together with c
  } fold_phase_e;

  localparam int unsigned GUARD_BITS = 2;  // headroom for three operands

endpackage

// File: rtl/fold_phase_ctr.sv
module fold_phase_ctr
  import fold_add_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  output fold_phase_e phase,
  output logic        is_even
);

  fold_phase_e phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_EVEN;
    end else begin
      phase_q <= (phase_q == PH_EVEN) ? PH_ODD : PH_EVEN;
    end
  end

  assign phase   = phase_q;
  assign is_even = (phase_q == PH_EVEN);

endmodule

// File: rtl/fold_sample_hold.sv
module fold_sample_hold #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is_even,
  input  logic              smp_vld,
  input  logic [DATA_W-1:0] opd_c,
  output logic [DATA_W-1:0] c_held,
  output logic              done_vld
);

  logic              tag_q;    // sample accepted in the current iteration
  logic              done_q;   // full sum sitting in the adder register
  logic [DATA_W-1:0] c_q;

  // c is captured with a and b so that only the even-phase port values count.
  always_ff @(posedge clk) begin
    if (rst) begin
      c_q <= '0;
    end else if (is_even) begin
      c_q <= opd_c;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (is_even) begin
      tag_q  <= smp_vld;
      done_q <= 1'b0;
    end else begin
      done_q <= tag_q;
    end
  end

  assign c_held   = c_q;
  assign done_vld = done_q;

endmodule

// File: rtl/fold_operand_mux.sv
module fold_operand_mux
  import fold_add_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SUM_W  = DATA_W + GUARD_BITS
) (
  input  fold_phase_e       phase,
  input  logic [DATA_W-1:0] opd_a,
  input  logic [DATA_W-1:0] opd_b,
  input  logic [DATA_W-1:0] c_held,
  input  logic [SUM_W-1:0]  partial,
  output logic [SUM_W-1:0]  op_x,
  output logic [SUM_W-1:0]  op_y
);

  function automatic logic [SUM_W-1:0] widen(input logic [DATA_W-1:0] v);
    return {{(SUM_W-DATA_W){v[DATA_W-1]}}, v};
  endfunction

  always_comb begin
    unique case (phase)
      PH_EVEN: begin
        op_x = widen(opd_a);
        op_y = widen(opd_b);
      end
      PH_ODD: begin
        op_x = partial;
        op_y = widen(c_held);
      end
      default: begin
        op_x = '0;
        op_y = '0;
      end
    endcase
  end

endmodule

// File: rtl/fold_pipe_adder.sv
module fold_pipe_adder #(
  parameter int unsigned SUM_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SUM_W-1:0] op_x,
  input  logic [SUM_W-1:0] op_y,
  output logic [SUM_W-1:0] sum_q
);

  // Wrapping add at the full result width; one register stage follows it.
  function automatic logic [SUM_W-1:0] wrap_add(input logic [SUM_W-1:0] x,
                                                input logic [SUM_W-1:0] y);
    return x + y;
  endfunction

  logic [SUM_W-1:0] sum_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_r <= '0;
    end else begin
      sum_r <= wrap_add(op_x, op_y);
    end
  end

  assign sum_q = sum_r;

endmodule

// File: rtl/tri_operand_folded_adder.sv
module tri_operand_folded_adder
  import fold_add_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         smp_vld,
  input  logic [DATA_W-1:0]            opd_a,
  input  logic [DATA_W-1:0]            opd_b,
  input  logic [DATA_W-1:0]            opd_c,
  output logic [DATA_W+GUARD_BITS-1:0] sum_out,
  output logic                         sum_vld
);

  localparam int unsigned SUM_W = DATA_W + GUARD_BITS;

  // Named internal events, also observed by the bound checker.
  fold_phase_e      phase;
  logic             is_even;
  logic [DATA_W-1:0] c_held;
  logic             done_vld;
  logic [SUM_W-1:0] op_x;
  logic [SUM_W-1:0] op_y;
  logic [SUM_W-1:0] acc_q;

  fold_phase_ctr u_phase (
    .clk     (clk),
    .rst     (rst),
    .phase   (phase),
    .is_even (is_even)
  );

  fold_sample_hold #(.DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .is_even  (is_even),
    .smp_vld  (smp_vld),
    .opd_c    (opd_c),
    .c_held   (c_held),
    .done_vld (done_vld)
  );

  fold_operand_mux #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_mux (
    .phase   (phase),
    .opd_a   (opd_a),
    .opd_b   (opd_b),
    .c_held  (c_held),
    .partial (acc_q),
    .op_x    (op_x),
    .op_y    (op_y)
  );

  fold_pipe_adder #(.SUM_W(SUM_W)) u_add (
    .clk   (clk),
    .rst   (rst),
    .op_x  (op_x),
    .op_y  (op_y),
    .sum_q (acc_q)
  );

  assign sum_out = acc_q;
  assign sum_vld = done_vld;

endmodule

// File: rtl/tri_operand_folded_adder_chk.sv
module tri_operand_folded_adder_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SUM_W  = DATA_W + 2
) (
  input logic              clk,
  input logic              rst,
  input logic              smp_vld,
  input logic [DATA_W-1:0] opd_a,
  input logic [DATA_W-1:0] opd_b,
  input logic [DATA_W-1:0] opd_c,
  input logic [SUM_W-1:0]  sum_out,
  input logic              sum_vld,
  input logic              is_even,
  input logic [SUM_W-1:0]  op_x,
  input logic [SUM_W-1:0]  op_y
);

  function automatic logic [SUM_W-1:0] sx(input logic [DATA_W-1:0] v);
    return {{(SUM_W-DATA_W){v[DATA_W-1]}}, v};
  endfunction

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!sum_vld && sum_out == '0));  // R1

  AST_FULL_SUM: assert property (@(posedge clk) disable iff (rst)
    sum_vld |-> (sum_out == sx($past(opd_a, 2)) + sx($past(opd_b, 2)) + sx($past(opd_c, 2))
                 && $past(smp_vld, 2)));  // R2

  AST_VALID_EVEN_ONLY: assert property (@(posedge clk) disable iff (rst)
    sum_vld |-> is_even);  // R3

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sum_vld |=> !sum_vld);  // R3

  AST_PHASE_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
    !is_even |=> is_even);  // R8

  AST_FEEDBACK_PARTIAL: assert property (@(posedge clk) disable iff (rst)
    (!is_even && !$past(rst)) |-> (op_x == sx($past(opd_a)) + sx($past(opd_b))));  // R7

  AST_FEEDBACK_THIRD: assert property (@(posedge clk) disable iff (rst)
    (!is_even && !$past(rst)) |-> (op_y == sx($past(opd_c))));  // R7

endmodule

bind tri_operand_folded_adder tri_operand_folded_adder_chk #(
  .DATA_W (DATA_W),
  .SUM_W  (SUM_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .smp_vld (smp_vld),
  .opd_a   (opd_a),
  .opd_b   (opd_b),
  .opd_c   (opd_c),
  .sum_out (sum_out),
  .sum_vld (sum_vld),
  .is_even (is_even),
  .op_x    (op_x),
  .op_y    (op_y)
);

// File: tb/tri_operand_folded_adder_bench.sv
module tri_operand_folded_adder_bench;

  localparam int NV = 10;
  // Stimulus: a, b, c, strobe; expected signed sum (ignored when strobe is 0).
  localparam int VA[NV]  = '{1, -1, 32767, -32768, 100, 5, 32767, -32768, 1234, 0};
  localparam int VB[NV]  = '{2, -1, 32767, -32768, -200, 6, 1, -1, -1234, 0};
  localparam int VC[NV]  = '{3, -1, 32767, -32768, 50, 7, 0, 0, 0, -32768};
  localparam bit VV[NV]  = '{1, 1, 1, 1, 1, 0, 1, 1, 1, 1};
  localparam int VE[NV]  = '{6, -3, 98301, -98304, -50, 0, 32768, -32769, 0, -32768};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_vld = 1'b0;
  logic [15:0] opd_a = '0;
  logic [15:0] opd_b = '0;
  logic [15:0] opd_c = '0;
  logic [17:0] sum_out;
  logic        sum_vld;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tri_operand_folded_adder u_tri_operand_folded_adder (
    .clk     (clk),
    .rst     (rst),
    .smp_vld (smp_vld),
    .opd_a   (opd_a),
    .opd_b   (opd_b),
    .opd_c   (opd_c),
    .sum_out (sum_out),
    .sum_vld (sum_vld)
  );

  task automatic chk_int(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int a, input int b, input int c, input bit v);
    opd_a   = 16'(a);
    opd_b   = 16'(b);
    opd_c   = 16'(c);
    smp_vld = v;
  endtask

  // Odd-phase values that would corrupt results if they were used (R4).
  task automatic drive_junk();
    drive(32767, -32768, 12345, 1'b1);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_int("R1 vld in reset", int'(sum_vld), 0);
    chk_int("R1 sum in reset", int'($signed(sum_out)), 0);

    rst = 1'b0;
    for (int i = 0; i <= NV; i++) begin
      // even-phase cycle: check the previous result (R2 R6 R7 R8 R5), offer next
      if (i == 0) begin
        chk_int("R1 vld cycle0", int'(sum_vld), 0);
      end else if (VV[i-1]) begin
        chk_int("R2 R6 R7 R8 vld", int'(sum_vld), 1);
        chk_int("R2 R6 R7 R8 sum", int'($signed(sum_out)), VE[i-1]);
      end else begin
        chk_int("R5 no vld", int'(sum_vld), 0);
      end
      if (i < NV) drive(VA[i], VB[i], VC[i], VV[i]);
      else        drive(0, 0, 0, 1'b0);
      @(posedge clk);
      @(negedge clk);
      // odd-phase cycle
      if (i == 0) chk_int("R1 vld cycle1", int'(sum_vld), 0);
      else        chk_int("R3 odd-phase vld", int'(sum_vld), 0);
      drive_junk();
      @(posedge clk);
      @(negedge clk);
    end

    // R4: result with odd-phase junk and differing operands held only one cycle
    drive(-7, 20000, 20000, 1'b1);
    @(posedge clk); @(negedge clk);
    drive(0, 0, 0, 1'b0);
    @(posedge clk); @(negedge clk);
    chk_int("R4 vld", int'(sum_vld), 1);
    chk_int("R4 sum", int'($signed(sum_out)), 39993);

    // R9: sample accepted, then reset before it completes
    drive(11, 22, 33, 1'b1);
    @(posedge clk); @(negedge clk);
    rst = 1'b1;
    drive(0, 0, 0, 1'b0);
    @(posedge clk); @(negedge clk);
    chk_int("R1 R9 vld in reset", int'(sum_vld), 0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk_int("R9 vld cycle1", int'(sum_vld), 0);
    @(posedge clk); @(negedge clk);
    chk_int("R9 vld cycle2", int'(sum_vld), 0);
    @(posedge clk); @(negedge clk);
    chk_int("R9 vld cycle3", int'(sum_vld), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule